// File: doc/BRIEF.md
# Sign-Bit Autocorrelation Matrix Accumulator

This block builds, over an accumulation window, the autocorrelation matrix of a stream of antipodal bit vectors, for use in multiuser channel estimation. Each vector holds 2K elements. A bit of 1 stands for +1 and a bit of 0 stands for -1. With this encoding the product of two elements is the XNOR of their bits, so the block has no multipliers. Every distinct off-diagonal pair (i, j) with i < j owns a saturating up/down counter. The XNOR of the pair's two bits steers that counter. All pairs update in the same clock cycle.

The diagonal product is always +1, so a single shared sample counter stands in for all diagonal entries. The lower triangle is not stored: a read of (r, c) with r > c returns entry (c, r). A select input picks the source of the vector. One source is the known training bits. The other is the detected bits fed back when the block is used for tracking.

A synchronous clear opens a new window. A valid strobe marks the cycles that count. The matrix is read one entry at a time through a combinational (row, column) port.

Top module: `acm_accumulator`

## Requirements
- R1: Bit value 1 encodes +1 and 0 encodes -1. On a counted update, the counter of each pair (i, j) with i ≠ j rises by one when bits i and j are equal and falls by one when they differ.
- R2: When `src_sel_i` = 0 the vector is taken from `train_bits_i`, and when it is 1 the vector is taken from `track_bits_i`. The source that is not selected has no effect.
- R3: The off-diagonal entries are 8-bit two's complement. They hold at +127 when counting up and at -128 when counting down, and never wrap.
- R4: Every diagonal entry equals the number of counted updates since the last clear or reset, held at +127 once it reaches that value.
- R5: A read of (r, c) with r > c returns the same value as a read of (c, r).
- R6: With `clear_i` high, every entry reads 0 after the next rising edge. Clear takes precedence over `upd_valid_i` in the same cycle.
- R7: A cycle with `upd_valid_i` low and `clear_i` low leaves every entry unchanged.
- R8: After synchronous reset every entry reads 0.
- R9: A counted update is visible on `rd_data_o` from the first rising edge after the cycle in which it was presented. The read path is combinational from the stored counters.
- R10: A read with a row or column index of 2K or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Synchronous clear of the whole matrix |
| upd_valid_i | input | 1 | Count the selected vector this cycle |
| src_sel_i | input | 1 | 0 = training bits, 1 = tracking bits |
| train_bits_i | input | 2K | Known training vector, one bit per element |
| track_bits_i | input | 2K | Detected-bit vector for tracking |
| rd_row_i | input | clog2(2K) | Read row index |
| rd_col_i | input | clog2(2K) | Read column index |
| rd_data_o | output | 8 | Signed entry (row, column) |

## Verification
The bench builds the block with K = 3. This gives a 6-element vector with 15 stored pairs and a 3-bit index. Index values 6 and 7 therefore exist on the read port, which puts the out-of-range reads of R10 within reach. The counters stay at the default 8 bits. Runs of more than 128 identical updates drive the diagonal and the agreeing pairs to the upper limit, and an alternating vector then drives the disagreeing pairs to the lower limit. After every clock, all 64 (row, column) combinations are compared against a full symmetric reference matrix.

// File: rtl/acm_pkg.sv
package acm_pkg;

    typedef enum logic {
        SRC_TRAIN = 1'b0,
        SRC_TRACK = 1'b1
    } acm_src_e;

    typedef struct packed {
        logic clr;
        logic en;
    } acm_cmd_t;

    // Linear slot of pair (lo, hi), lo < hi, in an n-element upper triangle
    function automatic int pair_slot(input int lo, input int hi, input int n);
        return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction

    function automatic int pair_count(input int n);
        return (n * (n - 1)) / 2;
    endfunction

endpackage

// File: rtl/acm_vec_select.sv
module acm_vec_select
    import acm_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  acm_src_e           src,
    input  logic [VEC_W-1:0]   train_bits,
    input  logic [VEC_W-1:0]   track_bits,
    output logic [VEC_W-1:0]   vec
);

    always_comb begin
        unique case (src)
            SRC_TRACK: vec = track_bits;
            default:   vec = train_bits;
        endcase
    end

endmodule

// File: rtl/acm_pair_products.sv
module acm_pair_products
    import acm_pkg::*;
#(
    parameter int VEC_W = 8,
    localparam int NPAIR = (VEC_W * (VEC_W - 1)) / 2
) (
    input  logic [VEC_W-1:0] vec,
    output logic [NPAIR-1:0] agree
);

    // agree = 1 means the antipodal product is +1
    for (genvar gi = 0; gi < VEC_W; gi++) begin : g_row
        for (genvar gj = gi + 1; gj < VEC_W; gj++) begin : g_col
            localparam int SLOT = pair_slot(gi, gj, VEC_W);
            assign agree[SLOT] = vec[gi] ~^ vec[gj];
        end
    end

endmodule

// File: rtl/acm_sat_counter.sv
module acm_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             up,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] MAXV = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] MINV = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            if (up && cnt_q != MAXV) begin
                cnt_q <= cnt_q + ONE;
            end else if (!up && cnt_q != MINV) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/acm_read_mux.sv
module acm_read_mux
    import acm_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CNT_W = 8,
    localparam int NPAIR  = (VEC_W * (VEC_W - 1)) / 2,
    localparam int IDX_W  = (VEC_W > 1) ? $clog2(VEC_W) : 1,
    localparam int PIDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  logic [IDX_W-1:0]            row,
    input  logic [IDX_W-1:0]            col,
    input  logic [NPAIR-1:0][CNT_W-1:0] pairs,
    input  logic [CNT_W-1:0]            diag,
    output logic [CNT_W-1:0]            data
);

    localparam logic [IDX_W:0] LIM = (IDX_W + 1)'(VEC_W);

    logic [IDX_W-1:0]  lo, hi;
    logic [PIDX_W-1:0] slot;

    always_comb begin
        lo   = (row < col) ? row : col;
        hi   = (row < col) ? col : row;
        slot = PIDX_W'(pair_slot(int'(lo), int'(hi), VEC_W));
        if ({1'b0, row} >= LIM || {1'b0, col} >= LIM) begin
            data = '0;
        end else if (row == col) begin
            data = diag;
        end else begin
            data = pairs[slot];
        end
    end

endmodule

// File: rtl/acm_accumulator.sv
module acm_accumulator
    import acm_pkg::*;
#(
    parameter int NUM_USERS = 4,
    parameter int CNT_W     = 8,
    localparam int VEC_W = 2 * NUM_USERS,
    localparam int NPAIR = (VEC_W * (VEC_W - 1)) / 2,
    localparam int IDX_W = (VEC_W > 1) ? $clog2(VEC_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             upd_valid_i,
    input  logic             src_sel_i,
    input  logic [VEC_W-1:0] train_bits_i,
    input  logic [VEC_W-1:0] track_bits_i,
    input  logic [IDX_W-1:0] rd_row_i,
    input  logic [IDX_W-1:0] rd_col_i,
    output logic [CNT_W-1:0] rd_data_o
);

    acm_cmd_t                  cmd;
    logic [VEC_W-1:0]          sel_vec;
    logic [NPAIR-1:0]          agree;
    logic [NPAIR-1:0][CNT_W-1:0] pair_cnt;
    logic [CNT_W-1:0]          diag_cnt;

    assign cmd.clr = clear_i;
    assign cmd.en  = upd_valid_i;

    acm_vec_select #(.VEC_W(VEC_W)) u_sel (
        .src        (acm_src_e'(src_sel_i)),
        .train_bits (train_bits_i),
        .track_bits (track_bits_i),
        .vec        (sel_vec)
    );

    acm_pair_products #(.VEC_W(VEC_W)) u_prod (
        .vec   (sel_vec),
        .agree (agree)
    );

    for (genvar gp = 0; gp < NPAIR; gp++) begin : g_pair
        acm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (cmd.clr),
            .en  (cmd.en),
            .up  (agree[gp]),
            .cnt (pair_cnt[gp])
        );
    end

    // shared diagonal: every update contributes +1
    acm_sat_counter #(.CNT_W(CNT_W)) u_diag (
        .clk (clk),
        .rst (rst),
        .clr (cmd.clr),
        .en  (cmd.en),
        .up  (1'b1),
        .cnt (diag_cnt)
    );

    acm_read_mux #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_rd (
        .row   (rd_row_i),
        .col   (rd_col_i),
        .pairs (pair_cnt),
        .diag  (diag_cnt),
        .data  (rd_data_o)
    );

endmodule

// File: rtl/acm_accumulator_chk.sv
module acm_accumulator_chk
    import acm_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CNT_W = 8,
    localparam int NPAIR = (VEC_W * (VEC_W - 1)) / 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        clr,
    input logic                        en,
    input logic [VEC_W-1:0]            vec,
    input logic [CNT_W-1:0]            diag,
    input logic [NPAIR-1:0][CNT_W-1:0] pairs
);

    localparam logic [CNT_W-1:0] MAXV = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] MINV = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pairs == '0 && diag == '0));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> ($stable(pairs) && $stable(diag)));

    p_diag_step_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && diag != MAXV) |=> (diag == $past(diag) + ONE));

    p_diag_cap_r4: assert property (@(posedge clk) disable iff (rst)
        (diag == MAXV && !clr) |=> (diag == MAXV));

    for (genvar gi = 0; gi < VEC_W; gi++) begin : g_row
        for (genvar gj = gi + 1; gj < VEC_W; gj++) begin : g_col
            localparam int S = pair_slot(gi, gj, VEC_W);

            p_count_up_r1: assert property (@(posedge clk) disable iff (rst)
                (en && !clr && vec[gi] == vec[gj] && pairs[S] != MAXV)
                |=> (pairs[S] == $past(pairs[S]) + ONE));

            p_count_dn_r1: assert property (@(posedge clk) disable iff (rst)
                (en && !clr && vec[gi] != vec[gj] && pairs[S] != MINV)
                |=> (pairs[S] == $past(pairs[S]) - ONE));

            p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
                (pairs[S] == MAXV) |=> (pairs[S] != MINV));

            p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
                (pairs[S] == MINV) |=> (pairs[S] != MAXV));
        end
    end

endmodule

bind acm_accumulator acm_accumulator_chk #(
    .VEC_W (VEC_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .clr   (clear_i),
    .en    (upd_valid_i),
    .vec   (sel_vec),
    .diag  (diag_cnt),
    .pairs (pair_cnt)
);

// File: tb/acm_accumulator_bench.sv
`timescale 1ns/100ps
module acm_accumulator_bench;

    localparam int K     = 3;
    localparam int N     = 2 * K;
    localparam int CW    = 8;
    localparam int IW    = 3;
    localparam int TOP   = 127;
    localparam int BOT   = -128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clear_i = 1'b0;
    logic          upd_valid_i = 1'b0;
    logic          src_sel_i = 1'b0;
    logic [N-1:0]  train_bits_i = '0;
    logic [N-1:0]  track_bits_i = '0;
    logic [IW-1:0] rd_row_i = '0;
    logic [IW-1:0] rd_col_i = '0;
    logic [CW-1:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    int model [N][N];

    always #10 clk = ~clk;

    acm_accumulator #(.NUM_USERS(K), .CNT_W(CW)) u_acm_accumulator (
        .clk          (clk),
        .rst          (rst),
        .clear_i      (clear_i),
        .upd_valid_i  (upd_valid_i),
        .src_sel_i    (src_sel_i),
        .train_bits_i (train_bits_i),
        .track_bits_i (track_bits_i),
        .rd_row_i     (rd_row_i),
        .rd_col_i     (rd_col_i),
        .rd_data_o    (rd_data_o)
    );

    task automatic model_zero();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                model[i][j] = 0;
    endtask

    task automatic model_update(input logic [N-1:0] v);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                int d;
                d = (v[i] == v[j]) ? 1 : -1;
                if (model[i][j] + d <= TOP && model[i][j] + d >= BOT)
                    model[i][j] = model[i][j] + d;
            end
    endtask

    // Compare every (row, col) combination, including out-of-range indices
    task automatic sweep(input string tag);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                int exp_v, got_v;
                string req;
                rd_row_i = IW'(r);
                rd_col_i = IW'(c);
                #0.1;
                exp_v = (r < N && c < N) ? model[r][c] : 0;
                got_v = int'($signed(rd_data_o));
                if (r >= N || c >= N) req = "R10";
                else if (r == c)      req = "R4";
                else if (r > c)       req = "R5";
                else                  req = tag;
                checks++;
                if (got_v != exp_v) begin
                    errors++;
                    $display("FAIL %s (%s) at (%0d,%0d): actual %0d expected %0d",
                             req, tag, r, c, got_v, exp_v);
                end
            end
    endtask

    task automatic step(input logic clr, input logic vld, input logic sel,
                        input logic [N-1:0] tr, input logic [N-1:0] tk,
                        input string tag);
        clear_i      = clr;
        upd_valid_i  = vld;
        src_sel_i    = sel;
        train_bits_i = tr;
        track_bits_i = tk;
        @(posedge clk);
        if (clr)      model_zero();
        else if (vld) model_update(sel ? tk : tr);
        @(negedge clk);
        sweep(tag);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        model_zero();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep("R8");

        // R1 / R9: several patterns, each visible after one edge
        step(1'b0, 1'b1, 1'b0, 6'b101100, 6'b000000, "R9");
        step(1'b0, 1'b1, 1'b0, 6'b111111, 6'b010101, "R1");
        step(1'b0, 1'b1, 1'b0, 6'b000111, 6'b111111, "R1");
        step(1'b0, 1'b1, 1'b0, 6'b011010, 6'b100101, "R1");

        // R2: tracking source, then training source with junk on the other
        step(1'b0, 1'b1, 1'b1, 6'b111111, 6'b110001, "R2");
        step(1'b0, 1'b1, 1'b1, 6'b000000, 6'b001011, "R2");
        step(1'b0, 1'b1, 1'b0, 6'b100001, 6'b011110, "R2");

        // R7: valid low, vectors wiggling
        step(1'b0, 1'b0, 1'b0, 6'b010101, 6'b101010, "R7");
        step(1'b0, 1'b0, 1'b1, 6'b110011, 6'b001100, "R7");

        // R6: clear with valid high
        step(1'b1, 1'b1, 1'b0, 6'b111111, 6'b000000, "R6");
        step(1'b0, 1'b1, 1'b0, 6'b001101, 6'b000000, "R1");
        step(1'b1, 1'b0, 1'b0, 6'b000000, 6'b000000, "R6");

        // R3: push to the upper limit, then drive disagreeing pairs low
        for (int n = 0; n < 140; n++)
            step(1'b0, 1'b1, 1'b0, 6'b111111, 6'b000000, "R3");
        for (int n = 0; n < 270; n++)
            step(1'b0, 1'b1, 1'b1, 6'b000000, 6'b010101, "R3");
        step(1'b0, 1'b1, 1'b0, 6'b110100, 6'b000000, "R3");
        step(1'b1, 1'b0, 1'b0, 6'b000000, 6'b000000, "R6");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule